// File: doc/BRIEF.md
# Tiered Issue Queue Transfer Allocator

This block decides, every cycle, which waiting operations move between the three tiers of an issue queue's slot array. The tiers are a few enqueue slots, which take new operations from the enqueue port, a middle tier of simple slots, and a final tier of complex slots. Operations only move toward the complex tier. A complex slot is never a source. A simple slot may only move to a complex slot. An enqueue slot may move to either the complex or the simple tier.

The allocator is purely combinational. Its inputs are the valid, issued and free flags of the slots and an age rank for each simple slot. Its outputs are a transfer select for every source slot and a one-hot destination vector per source. The surrounding slot storage uses these outputs to copy an operation and to clear its source at the next clock edge. A slot vacated by a transfer is reported free by that storage from the following cycle, so the allocator never reuses a slot in the cycle it is vacated. Defaults: 2 enqueue slots, 6 simple slots and 16 complex slots.

Top module: `tiered_xfer_alloc`

## Requirements
- R1: Only a slot that is valid with its issued flag clear may transfer. Complex slots have no transfer output.
- R2: The transferable enqueue slots move as one group. Either all of them transfer or none does. The one-bit tier output enq_to_comp_o is 1 for the complex tier and 0 for the simple tier.
- R3: The enqueue group goes to the complex tier only when four conditions all hold: every simple slot is free, no simple-to-complex move happens this cycle, there is at least one mover, and the number of free complex slots is at least the number of movers. Otherwise it goes to the simple tier if the free simple slots are at least as many as the movers. Otherwise it holds.
- R4: enq_ready_o is 1 exactly when every valid enqueue slot is transferring this cycle. A blocked or issued enqueue slot therefore drives it to 0.
- R5: The number of simple-to-complex moves equals the smallest of three counts: the transferable simple slots, the number of enqueue slots, and the free complex slots.
- R6: Simple-to-complex candidates are taken strictly oldest first. Simple slot i has a 3-bit age rank at bits [3i+2:3i] of simp_age_i, where 0 is the oldest and ranks are distinct.
- R7: Simple-to-complex moves claim free complex slots before any enqueue move. The k-th oldest mover receives the k-th lowest-indexed free complex slot.
- R8: The k-th enqueue mover, counted in ascending slot index, receives the k-th lowest-indexed free slot of its target tier. Enqueue slot e's destination vector is at bits [e*W+W-1:e*W] of its output, where W is the tier size. Simple slot i's complex destination is at bits [16i+15:16i]. A destination is always a free slot, and no slot is targeted twice.
- R9: With no valid slots, every transfer and destination output is 0 and enq_ready_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| enq_valid_i | input | 2 | Enqueue slot holds an operation |
| enq_issued_i | input | 2 | Enqueue slot's operation is in flight |
| simp_valid_i | input | 6 | Simple slot holds an operation |
| simp_issued_i | input | 6 | Simple slot's operation is in flight |
| simp_free_i | input | 6 | Simple slot may be written this cycle |
| simp_age_i | input | 18 | 3-bit age rank per simple slot, 0 oldest |
| comp_free_i | input | 16 | Complex slot may be written this cycle |
| enq_xfer_o | output | 2 | Enqueue slot transfers out |
| enq_to_comp_o | output | 1 | Enqueue group target tier, 1 = complex |
| enq_dst_simp_o | output | 12 | One-hot simple destination per enqueue slot |
| enq_dst_comp_o | output | 32 | One-hot complex destination per enqueue slot |
| enq_ready_o | output | 1 | Enqueue slots can take new operations |
| simp_xfer_o | output | 6 | Simple slot transfers out |
| simp_dst_comp_o | output | 96 | One-hot complex destination per simple slot |

## Verification
Every result of this block is due in the same cycle as its stimulus, because no register lies between any input and any output. The bench changes the inputs on the falling edge and reads all outputs one time unit after the next rising edge. By then the combinational paths have settled, and the next stimulus has not yet been applied. The same timing holds for the directed checks of destination slots, age order and enqueue holding, so each check sees exactly one input pattern.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  localparam int unsigned MAX_BITS = 64;

  // number of set bits in a vector of up to MAX_BITS bits
  function automatic int unsigned count_ones(input logic [MAX_BITS-1:0] v);
    int unsigned n;
    n = 0;
    for (int b = 0; b < MAX_BITS; b++) n += int'(v[b]);
    return n;
  endfunction

  // smallest of three counts
  function automatic int unsigned min3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a < b) ? a : b;
    return (m < c) ? m : c;
  endfunction
endpackage

// File: rtl/nth_free_pick.sv
module nth_free_pick #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned PICKS = 2,
  localparam int unsigned CW = $clog2(WIDTH + 1)
) (
  input  logic [WIDTH-1:0]       free_i,
  output logic [PICKS*WIDTH-1:0] pick_oh_o,
  output logic [CW-1:0]          free_cnt_o
);
  always_comb begin
    int unsigned seen;
    seen = 0;
    pick_oh_o = '0;
    for (int i = 0; i < int'(WIDTH); i++) begin
      if (free_i[i]) begin
        if (seen < PICKS) pick_oh_o[seen*WIDTH + i] = 1'b1;
        seen++;
      end
    end
    free_cnt_o = CW'(seen);
  end

  // R8: each pick names a free slot and at most one slot
  always_comb begin
    if (!$isunknown(free_i)) begin
      for (int k = 0; k < int'(PICKS); k++) begin
        pick_in_free_chk: assert ((pick_oh_o[k*WIDTH +: WIDTH] & ~free_i) == '0 &&
                                  $onehot0(pick_oh_o[k*WIDTH +: WIDTH]))
          else $error("pick %0d not a single free slot", k);
      end
    end
  end
endmodule

// File: rtl/age_order.sv
module age_order #(
  parameter int unsigned SLOTS = 6,
  localparam int unsigned RW = $clog2(SLOTS),
  localparam int unsigned CW = $clog2(SLOTS + 1)
) (
  input  logic [SLOTS-1:0]    cand_i,
  input  logic [SLOTS*RW-1:0] rank_i,
  output logic [SLOTS*CW-1:0] pos_o,
  output logic [CW-1:0]       cand_cnt_o
);
  // position of each candidate among candidates, 0 = oldest
  for (genvar i = 0; i < SLOTS; i++) begin : g_pos
    always_comb begin
      int unsigned older;
      older = 0;
      for (int j = 0; j < int'(SLOTS); j++) begin
        if (cand_i[j] && rank_i[j*RW +: RW] < rank_i[i*RW +: RW]) older++;
      end
      pos_o[i*CW +: CW] = CW'(older);
    end
  end

  assign cand_cnt_o = CW'(xfer_pkg::count_ones(xfer_pkg::MAX_BITS'(cand_i)));
endmodule

// File: rtl/tiered_xfer_alloc.sv
module tiered_xfer_alloc #(
  parameter int unsigned N_ENQ  = 2,
  parameter int unsigned N_SIMP = 6,
  parameter int unsigned N_COMP = 16,
  localparam int unsigned RW  = $clog2(N_SIMP),
  localparam int unsigned SCW = $clog2(N_SIMP + 1),
  localparam int unsigned CCW = $clog2(N_COMP + 1)
) (
  input  logic [N_ENQ-1:0]         enq_valid_i,
  input  logic [N_ENQ-1:0]         enq_issued_i,
  input  logic [N_SIMP-1:0]        simp_valid_i,
  input  logic [N_SIMP-1:0]        simp_issued_i,
  input  logic [N_SIMP-1:0]        simp_free_i,
  input  logic [N_SIMP*RW-1:0]     simp_age_i,
  input  logic [N_COMP-1:0]        comp_free_i,
  output logic [N_ENQ-1:0]         enq_xfer_o,
  output logic                     enq_to_comp_o,
  output logic [N_ENQ*N_SIMP-1:0]  enq_dst_simp_o,
  output logic [N_ENQ*N_COMP-1:0]  enq_dst_comp_o,
  output logic                     enq_ready_o,
  output logic [N_SIMP-1:0]        simp_xfer_o,
  output logic [N_SIMP*N_COMP-1:0] simp_dst_comp_o
);
  import xfer_pkg::*;

  // named internal events
  logic [N_ENQ-1:0]        enq_cand;
  logic [N_SIMP-1:0]       simp_cand;
  logic [N_SIMP*SCW-1:0]   simp_pos;
  logic [SCW-1:0]          simp_cand_cnt;
  logic [N_ENQ*N_COMP-1:0] comp_pick;
  logic [CCW-1:0]          comp_free_cnt;
  logic [N_ENQ*N_SIMP-1:0] simp_pick;
  logic [SCW-1:0]          simp_free_cnt;
  int unsigned             sc_moves;
  int unsigned             enq_cnt;
  logic                    simp_tier_empty;
  logic                    enq_go_comp;
  logic                    enq_go_simp;

  assign enq_cand  = enq_valid_i & ~enq_issued_i;
  assign simp_cand = simp_valid_i & ~simp_issued_i;

  age_order #(.SLOTS(N_SIMP)) u_age (
    .cand_i(simp_cand), .rank_i(simp_age_i),
    .pos_o(simp_pos), .cand_cnt_o(simp_cand_cnt)
  );

  nth_free_pick #(.WIDTH(N_COMP), .PICKS(N_ENQ)) u_comp_pick (
    .free_i(comp_free_i), .pick_oh_o(comp_pick), .free_cnt_o(comp_free_cnt)
  );

  nth_free_pick #(.WIDTH(N_SIMP), .PICKS(N_ENQ)) u_simp_pick (
    .free_i(simp_free_i), .pick_oh_o(simp_pick), .free_cnt_o(simp_free_cnt)
  );

  // simple -> complex: oldest first, bounded by enqueue width and free complex slots
  assign sc_moves = min3(int'(simp_cand_cnt), N_ENQ, int'(comp_free_cnt));

  for (genvar i = 0; i < N_SIMP; i++) begin : g_simp
    logic [SCW-1:0] pos;
    assign pos = simp_pos[i*SCW +: SCW];
    assign simp_xfer_o[i] = simp_cand[i] && (int'(pos) < sc_moves);
    assign simp_dst_comp_o[i*N_COMP +: N_COMP] =
      simp_xfer_o[i] ? comp_pick[int'(pos)*N_COMP +: N_COMP] : '0;
  end

  // enqueue group: complex tier only when simple tier empty, else simple, else hold
  assign enq_cnt         = count_ones(MAX_BITS'(enq_cand));
  assign simp_tier_empty = &simp_free_i;
  assign enq_go_comp     = (enq_cnt != 0) && simp_tier_empty && (sc_moves == 0) &&
                           (int'(comp_free_cnt) >= enq_cnt);
  assign enq_go_simp     = (enq_cnt != 0) && !enq_go_comp &&
                           (int'(simp_free_cnt) >= enq_cnt);

  assign enq_xfer_o    = (enq_go_comp || enq_go_simp) ? enq_cand : '0;
  assign enq_to_comp_o = enq_go_comp;
  assign enq_ready_o   = &(~enq_valid_i | enq_xfer_o);

  for (genvar e = 0; e < N_ENQ; e++) begin : g_enq
    int unsigned below;
    assign below = (e == 0) ? 0 : count_ones(MAX_BITS'(enq_cand & ((N_ENQ'(1) << e) - 1'b1)));
    assign enq_dst_comp_o[e*N_COMP +: N_COMP] =
      (enq_xfer_o[e] && enq_go_comp) ? comp_pick[below*N_COMP +: N_COMP] : '0;
    assign enq_dst_simp_o[e*N_SIMP +: N_SIMP] =
      (enq_xfer_o[e] && enq_go_simp) ? simp_pick[below*N_SIMP +: N_SIMP] : '0;
  end

  // ---------------- assertions next to the logic ----------------
  logic inputs_known;
  assign inputs_known = !$isunknown({enq_valid_i, enq_issued_i, simp_valid_i, simp_issued_i,
                                     simp_free_i, simp_age_i, comp_free_i});

  always_comb begin
    logic [N_COMP-1:0] comp_used;
    logic              comp_clash;
    comp_used  = '0;
    comp_clash = 1'b0;
    for (int i = 0; i < int'(N_SIMP); i++) begin
      comp_clash |= |(comp_used & simp_dst_comp_o[i*N_COMP +: N_COMP]);
      comp_used  |= simp_dst_comp_o[i*N_COMP +: N_COMP];
    end
    for (int e = 0; e < int'(N_ENQ); e++) begin
      comp_clash |= |(comp_used & enq_dst_comp_o[e*N_COMP +: N_COMP]);
      comp_used  |= enq_dst_comp_o[e*N_COMP +: N_COMP];
    end
    if (inputs_known) begin
      // R1
      only_idle_slots_move_chk: assert ((enq_xfer_o & ~enq_cand) == '0 &&
                                        (simp_xfer_o & ~simp_cand) == '0)
        else $error("transfer from a slot that may not move");
      // R2
      enq_all_or_none_chk: assert (enq_xfer_o == '0 || enq_xfer_o == enq_cand)
        else $error("enqueue group split");
      // R5
      simp_move_bound_chk: assert ($countones(simp_xfer_o) <= int'(N_ENQ) &&
                                   $countones(simp_xfer_o) <= int'(comp_free_cnt))
        else $error("too many simple moves");
      // R7
      comp_tier_shared_chk: assert (!(enq_to_comp_o && (simp_xfer_o != '0)))
        else $error("enqueue took complex slots beside simple moves");
      // R8
      comp_no_double_chk: assert (!comp_clash && (comp_used & ~comp_free_i) == '0)
        else $error("complex slot claimed twice or while busy");
    end
  end
endmodule

// File: tb/tiered_xfer_alloc_tb.sv
module tiered_xfer_alloc_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [17:0] ID = 18'o543210;  // slot i has rank i
  localparam logic [17:0] RV = 18'o012345;  // slot i has rank 5-i

  typedef struct packed {
    logic [1:0]  ev; logic [1:0] ei;
    logic [5:0]  sv; logic [5:0] si; logic [5:0] sf;
    logic [15:0] cf; logic [17:0] rk;
    logic [1:0]  x_enq; logic x_tc; logic [5:0] x_simp; logic x_rdy;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    '{2'b00,2'b00,6'h00,6'h00,6'h3F,16'hFFFF,ID,2'b00,1'b0,6'h00,1'b1}, // R9 idle
    '{2'b11,2'b00,6'h00,6'h00,6'h3F,16'hFFFF,ID,2'b11,1'b1,6'h00,1'b1}, // R3 to complex
    '{2'b11,2'b00,6'h01,6'h00,6'h3E,16'hFFFF,ID,2'b11,1'b0,6'h01,1'b1}, // R3 simple busy
    '{2'b11,2'b00,6'h3F,6'h00,6'h00,16'h0000,ID,2'b00,1'b0,6'h00,1'b0}, // R4 hold
    '{2'b00,2'b00,6'h3F,6'h00,6'h00,16'h0005,ID,2'b00,1'b0,6'h03,1'b1}, // R6 oldest
    '{2'b00,2'b00,6'h3F,6'h00,6'h00,16'h0005,RV,2'b00,1'b0,6'h30,1'b1}, // R6 reversed
    '{2'b00,2'b00,6'h3F,6'h00,6'h00,16'hFFFF,ID,2'b00,1'b0,6'h03,1'b1}, // R5 width cap
    '{2'b00,2'b00,6'h3F,6'h03,6'h00,16'hFFFF,ID,2'b00,1'b0,6'h0C,1'b1}, // R1 issued skip
    '{2'b11,2'b00,6'h00,6'h00,6'h3F,16'h0001,ID,2'b11,1'b0,6'h00,1'b1}, // R3 complex short
    '{2'b01,2'b00,6'h00,6'h00,6'h3F,16'h0001,ID,2'b01,1'b1,6'h00,1'b1}, // R3 single fits
    '{2'b11,2'b10,6'h00,6'h00,6'h3F,16'hFFFF,ID,2'b01,1'b1,6'h00,1'b0}, // R2 issued stays
    '{2'b11,2'b00,6'h3E,6'h3E,6'h01,16'hFFFF,ID,2'b00,1'b0,6'h00,1'b0}, // R2 one slot only
    '{2'b11,2'b00,6'h3F,6'h00,6'h00,16'h0001,ID,2'b00,1'b0,6'h01,1'b0}  // R7 simple first
  };

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [1:0] enq_valid, enq_issued, enq_xfer;
  logic [5:0] simp_valid, simp_issued, simp_free, simp_xfer;
  logic [17:0] simp_age;
  logic [15:0] comp_free;
  logic enq_to_comp, enq_ready;
  logic [11:0] enq_dst_simp;
  logic [31:0] enq_dst_comp;
  logic [95:0] simp_dst_comp;

  tiered_xfer_alloc dut_i (
    .enq_valid_i(enq_valid), .enq_issued_i(enq_issued),
    .simp_valid_i(simp_valid), .simp_issued_i(simp_issued),
    .simp_free_i(simp_free), .simp_age_i(simp_age), .comp_free_i(comp_free),
    .enq_xfer_o(enq_xfer), .enq_to_comp_o(enq_to_comp),
    .enq_dst_simp_o(enq_dst_simp), .enq_dst_comp_o(enq_dst_comp),
    .enq_ready_o(enq_ready), .simp_xfer_o(simp_xfer), .simp_dst_comp_o(simp_dst_comp)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // results are combinational: drive on falling edge, read just after rising edge
  task automatic apply(input vec_t v);
    @(negedge clk);
    enq_valid = v.ev; enq_issued = v.ei;
    simp_valid = v.sv; simp_issued = v.si; simp_free = v.sf;
    comp_free = v.cf; simp_age = v.rk;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R9: idle state before any traffic
    apply(TBL[0]);
    chk("R9 idle xfer", 96'({enq_xfer, simp_xfer}), 96'(0));
    chk("R9 idle dst", 96'(enq_dst_comp) | 96'(enq_dst_simp) | simp_dst_comp, 96'(0));
    chk("R9 idle ready", 96'(enq_ready), 96'(1));

    for (int n = 0; n < NV; n++) begin
      apply(TBL[n]);
      chk($sformatf("R2 vec%0d enq_xfer", n), 96'(enq_xfer), 96'(TBL[n].x_enq));
      chk($sformatf("R3 vec%0d tier", n), 96'(enq_to_comp), 96'(TBL[n].x_tc));
      chk($sformatf("R5 R6 vec%0d simp_xfer", n), 96'(simp_xfer), 96'(TBL[n].x_simp));
      chk($sformatf("R4 vec%0d ready", n), 96'(enq_ready), 96'(TBL[n].x_rdy));
    end

    // R8: enqueue to complex takes lowest free slots in index order
    apply(TBL[1]);
    chk("R8 enq0 comp dst", 96'(enq_dst_comp[15:0]), 96'(16'h0001));
    chk("R8 enq1 comp dst", 96'(enq_dst_comp[31:16]), 96'(16'h0002));
    chk("R8 no simp dst", 96'(enq_dst_simp), 96'(0));

    // R8, R7: enqueue to simple slots 1 and 2; simple slot 0 to complex slot 0
    apply(TBL[2]);
    chk("R8 enq0 simp dst", 96'(enq_dst_simp[5:0]), 96'(6'b000010));
    chk("R8 enq1 simp dst", 96'(enq_dst_simp[11:6]), 96'(6'b000100));
    chk("R7 simp0 comp dst", 96'(simp_dst_comp[15:0]), 96'(16'h0001));
    chk("R7 no enq comp dst", 96'(enq_dst_comp), 96'(0));

    // R7 R6: reversed ages, free complex slots 0 and 2
    apply(TBL[5]);
    chk("R7 oldest slot5 dst", 96'(simp_dst_comp[95:80]), 96'(16'h0001));
    chk("R7 next slot4 dst", 96'(simp_dst_comp[79:64]), 96'(16'h0004));
    chk("R7 slot0 idle", 96'(simp_dst_comp[15:0]), 96'(0));

    // R8: only enqueue slot 1 moves, it is mover 0
    apply('{2'b10,2'b00,6'h00,6'h00,6'h3F,16'hFFF0,ID,2'b10,1'b1,6'h00,1'b1});
    chk("R8 enq1 sole mover", 96'(enq_dst_comp[31:16]), 96'(16'h0010));
    chk("R8 enq0 no dst", 96'(enq_dst_comp[15:0]), 96'(0));
    chk("R1 enq1 only", 96'(enq_xfer), 96'(2'b10));

    // R4: held group keeps every destination clear
    apply(TBL[3]);
    chk("R4 held no dst", 96'(enq_dst_comp) | 96'(enq_dst_simp), 96'(0));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule